// File: doc/BRIEF.md
# Five-Stage Pipeline Control with Branch Squash and Load-Use Stall

This block is the control section of an in-order pipeline with five stages: fetch, register read and decode, execute, memory and writeback. Each cycle it takes the control-relevant bits of the fetched word: the opcode and three register numbers. It decodes them in the decode stage and sends the decoded fields down the pipe alongside the instruction. Those fields are a valid bit, the destination register, the writeback enable, the memory read and write controls, and the execute control. The register file, ALU and memories sit outside the block and follow the enables it drives.

All instructions that write a register do so in stage 5, so a register-register operation passes through the memory stage doing nothing. The register file therefore needs only one write port, and it never conflicts with loads. A branch compares its operands in execute; the compare result arrives on `ex_equal`. When the operands are equal the block selects the branch target for the PC. The single instruction after the branch still completes, and the instruction fetched in the same cycle that the branch resolves is squashed by clearing its valid bit. A consumer that directly follows a load and reads the load's destination is held in decode for one cycle, and a bubble enters execute.

Top module: `pipe_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, no stage holds a valid instruction: `ex_valid_o`, `mem_rd_o`, `mem_wr_o`, `wb_we`, `ovf_trap` and `stall` are 0.
- R2: The control word `if_ctl` has the opcode in bits [20:15], rs in [14:10], rt in [9:5] and rd in [4:0]. The opcodes are 0 register-register, 1 or-immediate, 2 load, 3 store and 4 branch-if-equal; any other value is a no-op. A word presented in cycle n is in execute in cycle n+2, where `ex_alu_o` shows 1 for load/store address, 2 for a register-register function, 3 for or-immediate, 4 for compare and 0 for a no-op. Without a stall, `if_en` and `id_en` stay high and one instruction enters every cycle.
- R3: Register-register, or-immediate and load instructions raise `wb_we` only in cycle n+4 (stage 5), never in cycle n+3. `wb_dst` is rd for register-register and rt for the other two.
- R4: A load raises `mem_rd_o` and a store raises `mem_wr_o` in cycle n+3. Stores and branches never raise `wb_we`.
- R5: `pc_sel` and `squash` are high exactly when a valid branch is in execute and `ex_equal` is high. `ex_equal` has no effect while any other instruction is in execute.
- R6: After a taken branch, the one following instruction (the delay slot) completes. The instruction fetched in the cycle the branch resolves shows `ex_valid_o` low two cycles later, and it causes no memory access and no register write.
- R7: `ovf_trap` rises in cycle n+2 only for a valid register-register instruction in execute while `ex_overflow` is high. A squashed instruction never raises it.
- R8: A valid load in execute with a non-zero destination stalls the decode-stage instruction when that instruction reads the same register. Register-register, store and branch read rs and rt; or-immediate and load read only rs. During the stall cycle `stall` is high and `if_en` and `id_en` are low. In the next cycle `ex_valid_o` is low, and the held instruction reaches execute one cycle later than it would have without the stall.
- R9: No stall occurs for a load whose destination is register 0, or when one unrelated instruction sits between the load and its consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| if_ctl | input | 21 | Opcode and register fields of the fetched word |
| ex_equal | input | 1 | Operand equality from the execute stage |
| ex_overflow | input | 1 | Arithmetic overflow from the execute stage |
| if_en | output | 1 | PC advance and fetch enable |
| id_en | output | 1 | Decode-stage register load enable |
| stall | output | 1 | Load-use hazard hold |
| pc_sel | output | 1 | Select branch target for the next PC |
| squash | output | 1 | Instruction fetched this cycle is discarded |
| ex_valid_o | output | 1 | Execute stage holds a live instruction |
| ex_alu_o | output | 3 | Execute operation code |
| ovf_trap | output | 1 | Overflow exception request |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| wb_we | output | 1 | Register file write enable |
| wb_dst | output | 5 | Register file write address |

## Verification
For a word presented in cycle n, a load-use stall shows in cycle n+1. The execute control, the PC select, the squash and the overflow request show in cycle n+2, the memory enables in n+3 and the register write in n+4; a stall pushes everything after decode one cycle later. The bench drives each program one word per cycle after a falling edge and records every output 1 ns later. It compares the recorded arrays at exactly those offsets, and it also checks the neighbouring cycle for write enables, so that a write in stage 4 instead of stage 5 is caught. Sweeps cover every opcode class, every hazard position and both branch outcomes against each class of wrong-path instruction.

// File: rtl/pipe_ctrl.sv
module pipe_ctrl #(
  parameter int OPW = 6,
  parameter int RN  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [OPW+3*RN-1:0]    if_ctl,
  input  logic                   ex_equal,
  input  logic                   ex_overflow,
  output logic                   if_en,
  output logic                   id_en,
  output logic                   stall,
  output logic                   pc_sel,
  output logic                   squash,
  output logic                   ex_valid_o,
  output logic [2:0]             ex_alu_o,
  output logic                   ovf_trap,
  output logic                   mem_rd_o,
  output logic                   mem_wr_o,
  output logic                   wb_we,
  output logic [RN-1:0]          wb_dst
);
  localparam int CW    = OPW + 3*RN;
  localparam int RS_HI = CW - OPW - 1;
  localparam int RT_HI = RS_HI - RN;
  localparam int RD_HI = RT_HI - RN;

  localparam logic [OPW-1:0] OP_REG = OPW'(0);
  localparam logic [OPW-1:0] OP_ORI = OPW'(1);
  localparam logic [OPW-1:0] OP_LD  = OPW'(2);
  localparam logic [OPW-1:0] OP_ST  = OPW'(3);
  localparam logic [OPW-1:0] OP_BR  = OPW'(4);

  // decode stage
  logic          id_valid;
  logic [CW-1:0] id_instr;

  logic [OPW-1:0] op;
  logic [RN-1:0]  rs, rt, rd;
  assign op = id_instr[CW-1 -: OPW];
  assign rs = id_instr[RS_HI -: RN];
  assign rt = id_instr[RT_HI -: RN];
  assign rd = id_instr[RD_HI -: RN];

  logic is_reg, is_ori, is_ld, is_st, is_br;
  assign is_reg = (op == OP_REG);
  assign is_ori = (op == OP_ORI);
  assign is_ld  = (op == OP_LD);
  assign is_st  = (op == OP_ST);
  assign is_br  = (op == OP_BR);

  logic          d_wb, uses_rs, uses_rt;
  logic [RN-1:0] d_dst;
  logic [2:0]    d_alu;
  assign d_wb    = is_reg | is_ori | is_ld;
  assign d_dst   = is_reg ? rd : rt;
  assign uses_rs = is_reg | is_ori | is_ld | is_st | is_br;
  assign uses_rt = is_reg | is_st | is_br;

  always_comb begin
    d_alu = 3'd0;
    if (is_ld | is_st) d_alu = 3'd1;
    if (is_reg)        d_alu = 3'd2;
    if (is_ori)        d_alu = 3'd3;
    if (is_br)         d_alu = 3'd4;
  end

  // execute stage
  logic          ex_valid, ex_wb, ex_mrd, ex_mwr, ex_br, ex_chk;
  logic [RN-1:0] ex_dst;
  logic [2:0]    ex_alu;

  // memory stage
  logic          mem_valid, mem_wb, mem_mrd, mem_mwr;
  logic [RN-1:0] mem_dst;

  // writeback stage
  logic          wb_valid, wb_wb;
  logic [RN-1:0] wb_dst_r;

  logic taken;
  assign taken = ex_valid & ex_br & ex_equal;

  assign stall = id_valid & ex_valid & ex_mrd & (ex_dst != '0) &
                 ((uses_rs & (rs == ex_dst)) | (uses_rt & (rt == ex_dst)));

  assign if_en  = ~stall;
  assign id_en  = ~stall;
  assign pc_sel = taken;
  assign squash = taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_valid  <= 1'b0;
      id_instr  <= '0;
      ex_valid  <= 1'b0;
      ex_wb     <= 1'b0;
      ex_mrd    <= 1'b0;
      ex_mwr    <= 1'b0;
      ex_br     <= 1'b0;
      ex_chk    <= 1'b0;
      ex_dst    <= '0;
      ex_alu    <= '0;
      mem_valid <= 1'b0;
      mem_wb    <= 1'b0;
      mem_mrd   <= 1'b0;
      mem_mwr   <= 1'b0;
      mem_dst   <= '0;
      wb_valid  <= 1'b0;
      wb_wb     <= 1'b0;
      wb_dst_r  <= '0;
    end else begin
      if (id_en) begin
        id_valid <= ~taken;
        id_instr <= if_ctl;
      end
      ex_valid  <= id_valid & ~stall;
      ex_wb     <= d_wb;
      ex_mrd    <= is_ld;
      ex_mwr    <= is_st;
      ex_br     <= is_br;
      ex_chk    <= is_reg;
      ex_dst    <= d_dst;
      ex_alu    <= d_alu;
      mem_valid <= ex_valid;
      mem_wb    <= ex_wb;
      mem_mrd   <= ex_mrd;
      mem_mwr   <= ex_mwr;
      mem_dst   <= ex_dst;
      wb_valid  <= mem_valid;
      wb_wb     <= mem_wb;
      wb_dst_r  <= mem_dst;
    end
  end

  assign ex_valid_o = ex_valid;
  assign ex_alu_o   = ex_valid ? ex_alu : 3'd0;
  assign ovf_trap   = ex_valid & ex_chk & ex_overflow;
  assign mem_rd_o   = mem_valid & mem_mrd;
  assign mem_wr_o   = mem_valid & mem_mwr;
  assign wb_we      = wb_valid & wb_wb;
  assign wb_dst     = wb_dst_r;
endmodule

// File: rtl/pipe_ctrl_chk.sv
module pipe_ctrl_chk #(
  parameter int CW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          squash,
  input logic          pc_sel,
  input logic          ex_valid_o,
  input logic          ovf_trap,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          wb_we,
  input logic          id_valid,
  input logic          mem_valid,
  input logic [CW-1:0] id_instr
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> !ex_valid_o && !wb_we && !mem_rd_o && !mem_wr_o);

  assert_stage5_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> $past(mem_valid));

  assert_one_mem_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_taken_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> !stall);

  assert_squash_kills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !id_valid);

  assert_trap_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> ex_valid_o);

  assert_stall_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid_o);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(id_instr) && id_valid);
endmodule

bind pipe_ctrl pipe_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .squash(squash), .pc_sel(pc_sel),
  .ex_valid_o(ex_valid_o), .ovf_trap(ovf_trap), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o), .wb_we(wb_we), .id_valid(id_valid),
  .mem_valid(mem_valid), .id_instr(id_instr)
);

// File: tb/tb_pipe_ctrl.sv
module tb_pipe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] if_ctl;
  logic        ex_equal = 1'b0, ex_overflow = 1'b0;
  logic        if_en, id_en, stall, pc_sel, squash, ex_valid_o, ovf_trap;
  logic        mem_rd_o, mem_wr_o, wb_we;
  logic [2:0]  ex_alu_o;
  logic [4:0]  wb_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .if_ctl(if_ctl), .ex_equal(ex_equal),
    .ex_overflow(ex_overflow), .if_en(if_en), .id_en(id_en), .stall(stall),
    .pc_sel(pc_sel), .squash(squash), .ex_valid_o(ex_valid_o),
    .ex_alu_o(ex_alu_o), .ovf_trap(ovf_trap), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .wb_we(wb_we), .wb_dst(wb_dst)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [20:0] p_i [NC];
  logic        p_e [NC];
  logic        p_o [NC];
  logic        r_stall [NC], r_ifen [NC], r_iden [NC], r_pcsel [NC], r_sq [NC];
  logic        r_exv [NC], r_trap [NC], r_mrd [NC], r_mwr [NC], r_we [NC];
  logic [2:0]  r_alu [NC];
  logic [4:0]  r_dst [NC];

  function automatic logic [20:0] mk(int op, int rs, int rt, int rd);
    return {6'(op), 5'(rs), 5'(rt), 5'(rd)};
  endfunction

  localparam logic [20:0] NOP = 21'h1F8000;

  function automatic int opc(int c);  return (c == 5) ? 63 : c; endfunction
  function automatic int code(int c);
    case (c)
      0: return 2;
      1: return 3;
      2: return 1;
      3: return 1;
      4: return 4;
      default: return 0;
    endcase
  endfunction
  function automatic bit writes(int c);  return c <= 2; endfunction
  function automatic bit reads_rs(int c); return c <= 4; endfunction
  function automatic bit reads_rt(int c); return c == 0 || c == 3 || c == 4; endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int k = 0; k < NC; k++) begin p_i[k] = NOP; p_e[k] = 1'b0; p_o[k] = 1'b0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; if_ctl = NOP; ex_equal = 1'b0; ex_overflow = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset ex_valid", int'(ex_valid_o), 0);
    check("R1 reset wb_we", int'(wb_we), 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int len);
    do_reset();
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if_ctl = p_i[k]; ex_equal = p_e[k]; ex_overflow = p_o[k];
      #1;
      r_stall[k] = stall; r_ifen[k] = if_en; r_iden[k] = id_en; r_pcsel[k] = pc_sel;
      r_sq[k] = squash; r_exv[k] = ex_valid_o; r_trap[k] = ovf_trap; r_mrd[k] = mem_rd_o;
      r_mwr[k] = mem_wr_o; r_we[k] = wb_we; r_alu[k] = ex_alu_o; r_dst[k] = wb_dst;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R2 watchdog act=timeout exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    if_ctl = NOP;
    // class sweep: one instruction alone, equal and overflow pulsed while it executes
    for (int c = 0; c < 6; c++) begin
      int en_cnt;
      clr();
      p_i[0] = mk(opc(c), 8, 9, 7);
      p_e[2] = 1'b1; p_o[2] = 1'b1;
      run(8);
      check("R1 first cycle ex_valid", int'(r_exv[0]), 0);
      check("R1 first cycle mem", int'(r_mrd[0] | r_mwr[0] | r_we[0] | r_trap[0] | r_stall[0]), 0);
      en_cnt = 0;
      for (int k = 0; k < 8; k++) en_cnt += int'(r_ifen[k] & r_iden[k]);
      check("R2 enables held high", en_cnt, 8);
      check("R2 ex_valid at n+2", int'(r_exv[2]), 1);
      check("R2 alu code at n+2", int'(r_alu[2]), code(c));
      check("R5 pc_sel", int'(r_pcsel[2]), (c == 4) ? 1 : 0);
      check("R5 squash", int'(r_sq[2]), (c == 4) ? 1 : 0);
      check("R7 overflow trap", int'(r_trap[2]), (c == 0) ? 1 : 0);
      check("R4 mem read n+3", int'(r_mrd[3]), (c == 2) ? 1 : 0);
      check("R4 mem write n+3", int'(r_mwr[3]), (c == 3) ? 1 : 0);
      for (int k = 0; k < 8; k++)
        check("R3 write only in stage 5", int'(r_we[k]), (writes(c) && k == 4) ? 1 : 0);
      if (writes(c)) check("R3 write address", int'(r_dst[4]), (c == 0) ? 7 : 9);
    end

    // load-use sweep
    for (int c = 0; c < 6; c++) begin
      for (int m = 0; m < 3; m++) begin
        int s;
        clr();
        p_i[0] = mk(2, 1, 3, 0);
        p_i[1] = mk(opc(c), (m == 0) ? 3 : 10, (m == 1) ? 3 : 11, 12);
        s = ((reads_rs(c) && m == 0) || (reads_rt(c) && m == 1)) ? 1 : 0;
        run(10);
        check("R8 stall", int'(r_stall[2]), s);
        check("R8 fetch enable", int'(r_ifen[2]), 1 - s);
        check("R8 decode enable", int'(r_iden[2]), 1 - s);
        check("R8 bubble", int'(r_exv[3]), 1 - s);
        check("R8 single stall cycle", int'(r_stall[3]), 0);
        check("R8 consumer alu", int'(r_alu[3 + s]), code(c));
        check("R3 load write", int'(r_we[4]), 1);
        check("R3 load dst", int'(r_dst[4]), 3);
        check("R8 write slot after bubble", int'(r_we[5]), (writes(c) && s == 0) ? 1 : 0);
        if (writes(c)) begin
          check("R8 consumer write", int'(r_we[5 + s]), 1);
          check("R8 consumer dst", int'(r_dst[5 + s]), (c == 0) ? 12 : ((m == 1) ? 3 : 11));
        end
      end
    end

    // no stall: load to register 0
    clr();
    p_i[0] = mk(2, 1, 0, 0);
    p_i[1] = mk(0, 0, 0, 12);
    run(6);
    check("R9 r0 load no stall", int'(r_stall[2]), 0);
    // no stall: one instruction in between
    clr();
    p_i[0] = mk(2, 1, 3, 0);
    p_i[2] = mk(0, 3, 3, 12);
    run(8);
    check("R9 gap no stall", int'(r_stall[3]) | int'(r_stall[2]), 0);
    check("R9 consumer executes on time", int'(r_alu[4]), 2);

    // branch sweep: delay slot survives, next fetch squashed when taken
    for (int w = 0; w < 4; w++) begin
      for (int e = 0; e < 2; e++) begin
        bit live;
        clr();
        p_i[0] = mk(4, 6, 7, 0);
        p_i[1] = mk(0, 1, 2, 5);
        p_i[2] = mk(w, 13, 8, 6);
        p_e[2] = 1'(e);
        p_o[4] = 1'b1;
        run(10);
        live = (e == 0);
        check("R5 taken select", int'(r_pcsel[2]), e);
        check("R5 taken squash", int'(r_sq[2]), e);
        check("R4 branch no write", int'(r_we[4]), 0);
        check("R6 delay slot write", int'(r_we[5]), 1);
        check("R6 delay slot dst", int'(r_dst[5]), 5);
        check("R6 shadow ex_valid", int'(r_exv[4]), int'(live));
        check("R7 shadow trap", int'(r_trap[4]), (live && w == 0) ? 1 : 0);
        check("R6 shadow mem read", int'(r_mrd[5]), (live && w == 2) ? 1 : 0);
        check("R6 shadow mem write", int'(r_mwr[5]), (live && w == 3) ? 1 : 0);
        check("R6 shadow write", int'(r_we[6]), (live && w <= 2) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule